// File: doc/BRIEF.md
# Range-Matching Translation Cache

This block is a small, fully associative address translation cache. Every entry describes a region of virtual address space with a start address and a length, plus the physical page that the region maps to. A lookup presents a virtual address and is answered in the same cycle. The answer gives a hit flag, the matching slot number and the physical address. The physical address is the entry's physical page ORed with the low page-offset bits of the lookup address. A separate write channel fills one slot per cycle. A clear input drops every entry at once.

Recency is tracked for all slots. A new entry goes into the lowest-numbered empty slot. When no slot is empty, it replaces the least recently used entry. A new entry always becomes the most recently used one. A lookup can refresh the recency of the entry it hits, or it can leave the order alone when the caller only wants to probe. When regions overlap, the most recently used matching entry answers.

The write channel uses valid/ready. A write is taken on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low only in cycles where `clear` is high; at all other times a write is accepted at once. The lookup side has no back-pressure, because it answers combinationally in the same cycle.

Top module: `range_tlb`

## Requirements
- R1: An entry with start B and length L matches address V only when B <= V and V < B + L. The sum is formed without wrap-around. A length of zero never matches.
- R2: On a hit, `lk_pa` equals the entry's physical page ORed with V[11:0], and `lk_slot` is the slot number. With no hit, `lk_pa` and `lk_slot` are 0. `lk_miss` is high exactly when `lk_valid` is high and `lk_hit` is low. `lk_hit` is never high while `lk_valid` is low.
- R3: After reset every slot is empty, so every lookup misses.
- R4: An accepted write goes into the lowest-numbered empty slot, if any slot is empty.
- R5: With no empty slot, an accepted write replaces the least recently used entry.
- R6: A newly written entry becomes the most recently used.
- R7: A lookup that hits with `lk_touch` = 1 makes the hit entry the most recently used. With `lk_touch` = 0 the recency order is left unchanged.
- R8: When several entries match, the most recently used of them is reported.
- R9: `clear` empties every slot by the next cycle. While `clear` is high, `wr_ready` is low and no write is taken.
- R10: When a write is accepted in the same cycle as a touching lookup, the lookup is still answered from the old contents, but its recency refresh is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Empty all slots |
| lk_valid | input | 1 | Lookup request present |
| lk_va | input | VA_W | Lookup virtual address |
| lk_touch | input | 1 | Refresh recency on hit |
| lk_hit | output | 1 | Lookup matched an entry |
| lk_miss | output | 1 | Lookup matched nothing |
| lk_pa | output | PA_W | Translated physical address |
| lk_slot | output | $clog2(N_SLOTS) | Slot that matched |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write accepted this cycle |
| wr_vbase | input | VA_W | Region start address |
| wr_span | input | VA_W | Region length in bytes |
| wr_ppage | input | PA_W | Physical page start |

## Verification
The bench probes the exact edges of each region: start-1, start, start+length-1 and start+length. A comparator that is off by one, or one that wraps, would report a hit one byte outside the region or miss the last byte. It builds eviction orders in which one entry is touched and another is only probed. A design that refreshed recency on a non-touching lookup, or that ignored a touch, would then evict the wrong slot. Later lookups show this as a hit on the wrong slot or an unexpected miss. It also overlaps regions, combines writes with touching lookups in the same cycle, and offers writes while `clear` is high. A wrong choice among several matches, a recency refresh that should have been dropped, or a write that slips in during a clear each show up as a mismatched slot number or hit flag.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    UPD_NONE  = 2'd0,
    UPD_WRITE = 2'd1,
    UPD_TOUCH = 2'd2
  } upd_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int VA_W = 32
) (
  input  logic            used,
  input  logic [VA_W-1:0] vbase,
  input  logic [VA_W-1:0] span,
  input  logic [VA_W-1:0] va,
  output logic            match
);
  logic [VA_W:0] limit;
  assign limit = {1'b0, vbase} + {1'b0, span};
  assign match = used && (va >= vbase) && ({1'b0, va} < limit);
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int N  = 8,
  parameter int AW = 3
) (
  input  logic [N-1:0]         match,
  input  logic [N-1:0][AW-1:0] age,
  output logic                 hit,
  output logic [AW-1:0]        slot
);
  logic [AW-1:0] best;
  always_comb begin
    hit  = 1'b0;
    slot = '0;
    best = '1;
    for (int i = 0; i < N; i++) begin
      if (match[i] && (!hit || age[i] < best)) begin
        hit  = 1'b1;
        slot = AW'(i);
        best = age[i];
      end
    end
  end
endmodule

// File: rtl/tlb_rank.sv
module tlb_rank #(
  parameter int N  = 8,
  parameter int AW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 promote,
  input  logic [AW-1:0]        pidx,
  output logic [N-1:0][AW-1:0] age,
  output logic [AW-1:0]        lru_slot
);
  localparam logic [AW-1:0] OLDEST = AW'(N - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age[i] <= AW'(i);
    end else if (promote) begin
      for (int i = 0; i < N; i++) begin
        if (AW'(i) == pidx)          age[i] <= '0;
        else if (age[i] < age[pidx]) age[i] <= age[i] + 1'b1;
      end
    end
  end

  always_comb begin
    lru_slot = '0;
    for (int i = 0; i < N; i++)
      if (age[i] == OLDEST) lru_slot = AW'(i);
  end
endmodule

// File: rtl/range_tlb.sv
module range_tlb
  import tlb_pkg::*;
#(
  parameter int N_SLOTS = 8,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFS_W   = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       lk_valid,
  input  logic [VA_W-1:0]            lk_va,
  input  logic                       lk_touch,
  output logic                       lk_hit,
  output logic                       lk_miss,
  output logic [PA_W-1:0]            lk_pa,
  output logic [$clog2(N_SLOTS)-1:0] lk_slot,
  input  logic                       wr_valid,
  output logic                       wr_ready,
  input  logic [VA_W-1:0]            wr_vbase,
  input  logic [VA_W-1:0]            wr_span,
  input  logic [PA_W-1:0]            wr_ppage
);
  localparam int AW = $clog2(N_SLOTS);

  logic [N_SLOTS-1:0]           used;
  logic [N_SLOTS-1:0][VA_W-1:0] vbase;
  logic [N_SLOTS-1:0][VA_W-1:0] span;
  logic [N_SLOTS-1:0][PA_W-1:0] ppage;
  logic [N_SLOTS-1:0][AW-1:0]   age;
  logic [N_SLOTS-1:0]           match;
  logic                         any_hit;
  logic [AW-1:0]                hit_slot, lru_slot, free_slot, victim;
  logic                         free_any, wr_fire;
  upd_e                         upd;

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_cmp
    tlb_match #(.VA_W(VA_W)) u_match (
      .used(used[g]), .vbase(vbase[g]), .span(span[g]),
      .va(lk_va), .match(match[g])
    );
  end

  tlb_pick #(.N(N_SLOTS), .AW(AW)) u_pick (
    .match(match), .age(age), .hit(any_hit), .slot(hit_slot)
  );

  assign lk_hit  = lk_valid && any_hit;
  assign lk_miss = lk_valid && !any_hit;
  assign lk_slot = lk_hit ? hit_slot : '0;
  assign lk_pa   = lk_hit ? (ppage[hit_slot] | PA_W'(lk_va[OFS_W-1:0])) : '0;

  assign wr_ready = !clear;
  assign wr_fire  = wr_valid && wr_ready;

  always_comb begin
    free_any  = 1'b0;
    free_slot = '0;
    for (int i = N_SLOTS - 1; i >= 0; i--) begin
      if (!used[i]) begin
        free_any  = 1'b1;
        free_slot = AW'(i);
      end
    end
  end

  assign victim = free_any ? free_slot : lru_slot;

  always_comb begin
    if (wr_fire)                             upd = UPD_WRITE;
    else if (lk_hit && lk_touch && !clear)   upd = UPD_TOUCH;
    else                                     upd = UPD_NONE;
  end

  tlb_rank #(.N(N_SLOTS), .AW(AW)) u_rank (
    .clk(clk), .rst_n(rst_n),
    .promote(upd != UPD_NONE),
    .pidx(upd == UPD_WRITE ? victim : hit_slot),
    .age(age), .lru_slot(lru_slot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used  <= '0;
      vbase <= '0;
      span  <= '0;
      ppage <= '0;
    end else if (clear) begin
      used <= '0;
    end else if (wr_fire) begin
      used[victim]  <= 1'b1;
      vbase[victim] <= wr_vbase;
      span[victim]  <= wr_span;
      ppage[victim] <= wr_ppage;
    end
  end
endmodule

// File: rtl/range_tlb_checker.sv
module range_tlb_checker #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFS_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clear,
  input logic            lk_valid,
  input logic [VA_W-1:0] lk_va,
  input logic            lk_hit,
  input logic            lk_miss,
  input logic [PA_W-1:0] lk_pa,
  input logic            wr_valid,
  input logic            wr_ready,
  input logic [VA_W-1:0] wr_vbase,
  input logic [VA_W-1:0] wr_span
);
  assert_hit_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_valid && !lk_miss));

  assert_miss_zero_pa_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_pa == '0));

  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ((lk_pa[OFS_W-1:0] & lk_va[OFS_W-1:0]) == lk_va[OFS_W-1:0]));

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !lk_hit);

  assert_write_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_valid && wr_ready && rst_n) && lk_valid && !clear &&
     lk_va == $past(wr_vbase) && $past(wr_span) != '0) |-> lk_hit);
endmodule

bind range_tlb range_tlb_checker #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .lk_valid(lk_valid), .lk_va(lk_va),
  .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pa(lk_pa), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_vbase(wr_vbase), .wr_span(wr_span)
);

// File: tb/range_tlb_tb.sv
`timescale 1ns/1ps
module range_tlb_tb;
  localparam int N  = 8;
  localparam int AW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0, clear = 1'b0;
  logic lk_valid = 1'b0, lk_touch = 1'b0, wr_valid = 1'b0;
  logic [31:0] lk_va = '0, wr_vbase = '0, wr_span = '0, wr_ppage = '0;
  logic lk_hit, lk_miss, wr_ready;
  logic [31:0] lk_pa;
  logic [AW-1:0] lk_slot;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  range_tlb #(.N_SLOTS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .lk_valid(lk_valid), .lk_va(lk_va),
    .lk_touch(lk_touch), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pa(lk_pa),
    .lk_slot(lk_slot), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_vbase(wr_vbase), .wr_span(wr_span), .wr_ppage(wr_ppage)
  );

  // reference model: ord[0] is most recent
  bit          m_used [N];
  logic [31:0] m_base [N], m_span [N], m_pp [N];
  int          ord [N];

  function automatic bit in_rng(int k, logic [31:0] va);
    return m_used[k] && va >= m_base[k] && {1'b0, va} < ({1'b0, m_base[k]} + {1'b0, m_span[k]});
  endfunction

  function automatic int m_find(logic [31:0] va);
    for (int p = 0; p < N; p++) if (in_rng(ord[p], va)) return ord[p];
    return -1;
  endfunction

  function automatic void m_promote(int k);
    int p = 0;
    for (int q = 0; q < N; q++) if (ord[q] == k) p = q;
    for (int q = p; q > 0; q--) ord[q] = ord[q-1];
    ord[0] = k;
  endfunction

  function automatic int m_victim();
    for (int k = 0; k < N; k++) if (!m_used[k]) return k;
    return ord[N-1];
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, bit f, bit lv, bit lt, logic [31:0] va,
                      bit wv, logic [31:0] b, logic [31:0] s, logic [31:0] p);
    int k;
    bit eh;
    @(negedge clk);
    clear = f; lk_valid = lv; lk_touch = lt; lk_va = va;
    wr_valid = wv; wr_vbase = b; wr_span = s; wr_ppage = p;
    #1;
    k  = lv ? m_find(va) : -1;
    eh = (k >= 0);
    chk(req, "hit", 32'(lk_hit), 32'(eh));
    chk(req, "miss", 32'(lk_miss), 32'(lv && !eh));
    chk(req, "slot", 32'(lk_slot), eh ? 32'(k) : 32'd0);
    chk(req, "pa", lk_pa, eh ? (m_pp[k] | {20'd0, va[11:0]}) : 32'd0);
    chk(req, "ready", 32'(wr_ready), 32'(!f));
    @(posedge clk);
    if (f) begin
      for (int i = 0; i < N; i++) m_used[i] = 0;
    end else if (wv) begin
      int v = m_victim();
      m_used[v] = 1; m_base[v] = b; m_span[v] = s; m_pp[v] = p;
      m_promote(v);
    end else if (eh && lt) begin
      m_promote(k);
    end
  endtask

  task automatic look(string req, logic [31:0] va, bit t);
    step(req, 0, 1, t, va, 0, 0, 0, 0);
  endtask

  task automatic put(string req, logic [31:0] b, logic [31:0] s, logic [31:0] p);
    step(req, 0, 0, 0, 0, 1, b, s, p);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin m_used[i] = 0; ord[i] = i; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    look("R3", 32'h0000_1000, 1);
    look("R3", 32'h0000_0000, 0);

    for (int i = 0; i < N; i++)
      put("R4", 32'h1_0000 * (i + 1), 32'h2000, 32'hA000_0000 + (i << 16));
    for (int i = 0; i < N; i++) look("R4", 32'h1_0000 * (i + 1) + 32'h123, 0);

    look("R1", 32'h3_0000 - 1, 0);
    look("R1", 32'h3_0000, 0);
    look("R1", 32'h3_1FFF, 0);
    look("R1", 32'h3_2000, 0);
    look("R2", 32'h5_0ABC, 0);

    look("R7", 32'h1_0010, 1);   // refresh slot 0
    look("R7", 32'h2_0010, 0);   // probe slot 1 only
    put("R5", 32'hC0_0000, 32'h1000, 32'hB000_0000);
    look("R5", 32'h2_0010, 0);
    look("R5", 32'hC0_0FFF, 0);

    put("R6", 32'h4_1000, 32'h4000, 32'hC000_0000);
    look("R8", 32'h4_1500, 0);
    look("R8", 32'h4_0500, 1);
    look("R8", 32'h4_1500, 0);

    step("R10", 0, 1, 1, 32'h5_0100, 1, 32'hD0_0000, 32'h1000, 32'hD000_0000);
    put("R10", 32'hE0_0000, 32'h1000, 32'hE000_0000);
    look("R10", 32'h5_0100, 0);
    look("R1", 32'hF0_0000, 0);
    put("R1", 32'hF0_0000, 32'h0, 32'hF000_0000);
    look("R1", 32'hF0_0000, 0);

    step("R9", 1, 1, 0, 32'h6_0000, 1, 32'h9_0000, 32'h1000, 32'h9000_0000);
    look("R9", 32'h6_0000, 0);
    look("R9", 32'h9_0000, 0);
    put("R4", 32'h7_0000, 32'h1000, 32'h7000_0000);
    look("R4", 32'h7_0040, 0);

    for (int n = 0; n < 3000; n++) begin
      int r = $urandom % 100;
      logic [31:0] b = ($urandom % 12) << 13;
      logic [31:0] s = ($urandom % 4) << 12;
      logic [31:0] p = $urandom & 32'hFFFF_F000;
      logic [31:0] va = $urandom % (14 << 13);
      step("R2", r < 2, r >= 15 || ($urandom % 2 == 1), $urandom % 2 == 1, va,
           r >= 2 && r < 30, b, s, p);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule